// File: doc/BRIEF.md
# Scrubbed Triple-Redundant Memory

This block is a single-port user memory built from three identical RAM arrays that share address, write data and write strobe. Every write lands in all three arrays. Every read returns the bitwise majority of the three array outputs, so an upset in any one array never reaches the reader. When copies disagree on a read, a corrected-error flag pulses and a saturating counter advances.

Voting alone cannot stop upsets from piling up: two hits in different arrays at the same word defeat the majority. A background scrubber therefore uses the memory port whenever the user leaves it idle. On one idle cycle it reads a word. On the next idle cycle it writes the voted value back to all three arrays. It then steps to the next address and wraps to zero at the end. User traffic always wins the port, so the memory stays fully usable while it is being refreshed. A test port can flip any chosen bit of any chosen array at any address, which lets a bench drive the correction paths.

Top module: `tmr_scrub_mem`

## Requirements
- R1: A user write (`u_we` high) stores `u_wdata` at `u_addr` in all three arrays. A user read (`u_re` high, `u_we` low) presents the stored word on `rdata` with `rvalid` high in the following cycle.
- R2: `rdata` is the bitwise majority of the three arrays. A single flipped bit in any one array never changes the returned word.
- R3: `corr_err` is high in the cycle a user read result, or a scrub read result, shows any array differing from the vote. `err_count` then rises by one at the next edge and saturates at all ones. A read on which the arrays agree leaves `corr_err` low.
- R4: User accesses have priority. In any cycle with `u_re` or `u_we` high, the scrubber neither reads nor writes, and `scrub_addr` holds.
- R5: While the port is idle, the scrubber alternates between a read cycle and a write-back cycle. `scrub_addr` advances by exactly one per completed pair and wraps from the last address to 0.
- R6: After a scrub pass covers a word, that word's upset is repaired in all arrays. A later read then reports no disagreement, and a second upset of the same bit in a different array does not corrupt the word.
- R7: `pass_done` pulses for one cycle each time `scrub_addr` wraps to 0, with `scrub_addr` equal to 0 in that cycle. It pulses exactly twice in any 4*DEPTH consecutive idle cycles.
- R8: If the user takes the port in the cycle the scrubber would write back, the write-back is dropped and the same address is read again. A user write in that cycle survives, and `scrub_addr` does not advance.
- R9: With `inj_en` high, bit `inj_bit` of array `inj_copy` (0, 1 or 2) at `inj_addr` is inverted at the clock edge. `inj_copy` = 3 selects no array. A write to the same address in the same cycle takes precedence over the flip.
- R10: Synchronous active-low reset clears all arrays to zero and drives `rvalid`, `corr_err`, `err_count`, `pass_done` and `scrub_addr` to zero.
- R11: With `u_we` and `u_re` both high, the cycle is a write only, and `rvalid` stays low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| u_addr | input | ADDR_W | User word address |
| u_wdata | input | DATA_W | User write data |
| u_we | input | 1 | User write strobe |
| u_re | input | 1 | User read strobe |
| inj_en | input | 1 | Test: apply a bit flip this cycle |
| inj_copy | input | 2 | Test: array to corrupt (0..2, 3 = none) |
| inj_addr | input | ADDR_W | Test: word to corrupt |
| inj_bit | input | $clog2(DATA_W) | Test: bit to invert |
| rdata | output | DATA_W | Voted read data |
| rvalid | output | 1 | `rdata` holds a user read result |
| corr_err | output | 1 | Arrays disagreed on the current read result |
| err_count | output | CNT_W | Saturating count of disagreements |
| scrub_addr | output | ADDR_W | Next word the scrubber will refresh |
| pass_done | output | 1 | Scrubber wrapped to address 0 |

## Verification
The bench hits each array in turn and checks that the vote hides the flip. A voter that favoured one array would return the corrupted word. It lets a fault sit through a full idle pass and then injects the same bit into a second array. A scrubber that never wrote back, or wrote the raw array value, would then hand out a wrong majority. It places a user write on the exact cycle of a pending write-back, aligned by the wrap pulse. A design that ignored the conflict would overwrite fresh data or skip the word. It also holds the port busy to confirm the scrubber stalls, counts wrap pulses over a fixed idle window, and drives the error counter into saturation, where a wrapping counter would fall back to zero.

// File: rtl/tmr_scrub_pkg.sv
// Shared definitions for the scrubbed triple-redundant memory.
// Assumes nothing beyond the standard; holds constants and the scrub phase type.
package tmr_scrub_pkg;

    // Number of redundant arrays; the voter is written for exactly three.
    localparam int unsigned NUM_COPIES = 3;

    // Scrubber phase: fetch a word, then write its voted value back.
    typedef enum logic {
        PH_FETCH = 1'b0,
        PH_FIX   = 1'b1
    } scrub_phase_e;

endpackage

// File: rtl/tmr_ram_copy.sv
// One of the three redundant arrays.
// Synchronous write, synchronous registered read; the read register only
// updates on a read so it keeps the last fetched word. Includes a test-only
// bit flip that a write to the same word in the same cycle overrides.
// Assumes DEPTH is small enough for a reset loop over all words.
module tmr_ram_copy #(
    parameter int unsigned ADDR_W  = 4,
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned COPY_ID = 0,
    localparam int unsigned DEPTH  = 1 << ADDR_W,
    localparam int unsigned BIT_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              we,
    input  logic              re,
    input  logic              inj_en,
    input  logic [1:0]        inj_copy,
    input  logic [ADDR_W-1:0] inj_addr,
    input  logic [BIT_W-1:0]  inj_bit,
    output logic [DATA_W-1:0] q
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic              inj_hit;

    // Flip applies to this array only, and only if no write targets the word.
    always_comb inj_hit = inj_en && (inj_copy == 2'(COPY_ID)) && !(we && (addr == inj_addr));

    // Array storage: reset clear, write, test flip.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (we) mem[addr] <= wdata;
            if (inj_hit) mem[inj_addr][inj_bit] <= ~mem[inj_addr][inj_bit];
        end
    end

    // Read register: captures the addressed word on a read, else holds.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (re) q <= mem[addr];
    end

endmodule

// File: rtl/tmr_voter.sv
// Bitwise two-of-three majority with a disagreement indicator.
// Purely combinational; assumes its three inputs come from the arrays'
// read registers.
module tmr_voter #(
    parameter int unsigned DATA_W = 8
) (
    input  logic [2:0][DATA_W-1:0] q,
    output logic [DATA_W-1:0]      voted,
    output logic                   mismatch
);

    // Majority per bit, then flag any array that departs from it.
    always_comb begin
        voted    = (q[0] & q[1]) | (q[0] & q[2]) | (q[1] & q[2]);
        mismatch = |((q[0] ^ voted) | (q[1] ^ voted) | (q[2] ^ voted));
    end

endmodule

// File: rtl/tmr_scrub_ctrl.sv
// Background scrub sequencer.
// Uses the port only in cycles the user leaves idle: one idle cycle fetches
// the word at the scrub address, the next idle cycle writes the voted value
// back and advances the address with wraparound. If the user takes the
// port in the write-back cycle, the fetch is repeated for the same address.
// Assumes the array read registers change only on reads.
module tmr_scrub_ctrl
    import tmr_scrub_pkg::*;
#(
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              port_busy,
    output logic [ADDR_W-1:0] addr,
    output logic              rd_req,
    output logic              wr_req,
    output logic              rd_done,
    output logic              wrapped
);

    scrub_phase_e phase;

    // Port requests: granted only when the user is idle.
    always_comb begin
        rd_req = (phase == PH_FETCH) && !port_busy;
        wr_req = (phase == PH_FIX)   && !port_busy;
    end

    // Phase, address and pulse outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_FETCH;
            addr    <= '0;
            rd_done <= 1'b0;
            wrapped <= 1'b0;
        end else begin
            rd_done <= rd_req;
            wrapped <= 1'b0;
            case (phase)
                PH_FETCH: if (rd_req) phase <= PH_FIX;
                PH_FIX: begin
                    phase <= PH_FETCH;
                    if (wr_req) begin
                        addr <= addr + 1'b1;
                        if (addr == '1) wrapped <= 1'b1;
                    end
                end
                default: phase <= PH_FETCH;
            endcase
        end
    end

endmodule

// File: rtl/tmr_scrub_mem.sv
// Scrubbed triple-redundant memory, top level.
// Three arrays share one port. The user has priority on that port and the
// scrubber fills idle cycles. Reads are voted; disagreements pulse corr_err
// and advance a saturating counter. Assumes the user holds inj_* low
// outside tests.
module tmr_scrub_mem
    import tmr_scrub_pkg::*;
#(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned CNT_W  = 8,
    localparam int unsigned BIT_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] u_addr,
    input  logic [DATA_W-1:0] u_wdata,
    input  logic              u_we,
    input  logic              u_re,
    input  logic              inj_en,
    input  logic [1:0]        inj_copy,
    input  logic [ADDR_W-1:0] inj_addr,
    input  logic [BIT_W-1:0]  inj_bit,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid,
    output logic              corr_err,
    output logic [CNT_W-1:0]  err_count,
    output logic [ADDR_W-1:0] scrub_addr,
    output logic              pass_done
);

    logic                         user_busy;
    logic                         user_rd;
    logic                         user_rd_q;
    logic                         scr_rd, scr_wr, scr_rd_q;
    logic [ADDR_W-1:0]            port_addr;
    logic [DATA_W-1:0]            port_wdata;
    logic                         port_we, port_re;
    logic [NUM_COPIES-1:0][DATA_W-1:0] copy_q;
    logic [DATA_W-1:0]            voted;
    logic                         mismatch;

    // User decode: a write wins over a read in the same cycle.
    always_comb begin
        user_busy = u_we || u_re;
        user_rd   = u_re && !u_we;
    end

    tmr_scrub_ctrl #(.ADDR_W(ADDR_W)) u_scrub (
        .clk       (clk),
        .rst_n     (rst_n),
        .port_busy (user_busy),
        .addr      (scrub_addr),
        .rd_req    (scr_rd),
        .wr_req    (scr_wr),
        .rd_done   (scr_rd_q),
        .wrapped   (pass_done)
    );

    // Port mux: user fields when busy, scrubber fields otherwise.
    always_comb begin
        port_addr  = user_busy ? u_addr : scrub_addr;
        port_wdata = u_we ? u_wdata : voted;
        port_we    = u_we || scr_wr;
        port_re    = user_rd || scr_rd;
    end

    for (genvar c = 0; c < NUM_COPIES; c++) begin : g_copy
        tmr_ram_copy #(
            .ADDR_W  (ADDR_W),
            .DATA_W  (DATA_W),
            .COPY_ID (c)
        ) u_copy (
            .clk      (clk),
            .rst_n    (rst_n),
            .addr     (port_addr),
            .wdata    (port_wdata),
            .we       (port_we),
            .re       (port_re),
            .inj_en   (inj_en),
            .inj_copy (inj_copy),
            .inj_addr (inj_addr),
            .inj_bit  (inj_bit),
            .q        (copy_q[c])
        );
    end

    tmr_voter #(.DATA_W(DATA_W)) u_vote (
        .q        (copy_q),
        .voted    (voted),
        .mismatch (mismatch)
    );

    // Marks the cycle after a user read, when its result is on the arrays.
    always_ff @(posedge clk) begin
        if (!rst_n) user_rd_q <= 1'b0;
        else        user_rd_q <= user_rd;
    end

    // Result outputs and disagreement flag for user and scrub reads.
    always_comb begin
        rdata    = voted;
        rvalid   = user_rd_q;
        corr_err = (user_rd_q || scr_rd_q) && mismatch;
    end

    // Saturating disagreement counter.
    always_ff @(posedge clk) begin
        if (!rst_n)                           err_count <= '0;
        else if (corr_err && err_count != '1) err_count <= err_count + 1'b1;
    end

endmodule

// File: rtl/tmr_scrub_mem_chk.sv
// Property checker for tmr_scrub_mem, attached by bind. Observes ports only.
module tmr_scrub_mem_chk #(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned CNT_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              u_we,
    input logic              u_re,
    input logic              rvalid,
    input logic              corr_err,
    input logic [CNT_W-1:0]  err_count,
    input logic [ADDR_W-1:0] scrub_addr,
    input logic              pass_done
);

    a_r11_rvalid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (rvalid == $past(u_re && !u_we)));

    a_r4_busy_holds_scrub: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(u_re || u_we)) |-> $stable(scrub_addr));

    a_r5_scrub_steps_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$stable(scrub_addr)) |-> (scrub_addr == ADDR_W'($past(scrub_addr) + 1'b1)));

    a_r7_wrap_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        pass_done |-> (scrub_addr == '0));

    a_r3_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(corr_err) && ($past(err_count) != '1))
            |-> (err_count == CNT_W'($past(err_count) + 1'b1)));

    a_r3_count_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(corr_err)) |-> $stable(err_count));

endmodule

bind tmr_scrub_mem tmr_scrub_mem_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .u_we       (u_we),
    .u_re       (u_re),
    .rvalid     (rvalid),
    .corr_err   (corr_err),
    .err_count  (err_count),
    .scrub_addr (scrub_addr),
    .pass_done  (pass_done)
);

// File: tb/tmr_scrub_mem_bench.sv
module tmr_scrub_mem_bench;

    localparam int ADDR_W = 4;
    localparam int DATA_W = 8;
    localparam int CNT_W  = 8;
    localparam int BIT_W  = $clog2(DATA_W);
    localparam int DEPTH  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] u_addr = '0;
    logic [DATA_W-1:0] u_wdata = '0;
    logic              u_we = 1'b0, u_re = 1'b0;
    logic              inj_en = 1'b0;
    logic [1:0]        inj_copy = 2'd3;
    logic [ADDR_W-1:0] inj_addr = '0;
    logic [BIT_W-1:0]  inj_bit = '0;
    logic [DATA_W-1:0] rdata;
    logic              rvalid, corr_err, pass_done;
    logic [CNT_W-1:0]  err_count;
    logic [ADDR_W-1:0] scrub_addr;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    tmr_scrub_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_tmr_scrub_mem (
        .clk(clk), .rst_n(rst_n), .u_addr(u_addr), .u_wdata(u_wdata),
        .u_we(u_we), .u_re(u_re), .inj_en(inj_en), .inj_copy(inj_copy),
        .inj_addr(inj_addr), .inj_bit(inj_bit), .rdata(rdata), .rvalid(rvalid),
        .corr_err(corr_err), .err_count(err_count), .scrub_addr(scrub_addr),
        .pass_done(pass_done)
    );

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        u_we = 1'b1; u_addr = a; u_wdata = d;
        @(negedge clk);
        u_we = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d,
                      output logic v, output logic e);
        u_re = 1'b1; u_addr = a;
        @(negedge clk);
        d = rdata; v = rvalid; e = corr_err;
        u_re = 1'b0;
    endtask

    // Flip while a dummy read holds the port so no scrub write coincides.
    task automatic inj(input logic [1:0] c, input logic [ADDR_W-1:0] a, input int b);
        inj_en = 1'b1; inj_copy = c; inj_addr = a; inj_bit = BIT_W'(b);
        u_re = 1'b1; u_addr = a;
        @(negedge clk);
        inj_en = 1'b0; u_re = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [DATA_W-1:0] d; logic v, e;
        check("R10 rvalid", rvalid, 0);
        check("R10 corr_err", corr_err, 0);
        check("R10 err_count", err_count, 0);
        check("R10 scrub_addr", scrub_addr, 0);
        check("R10 pass_done", pass_done, 0);
        rd(4'd3, d, v, e);
        check("R10 cleared word", d, 0);
    endtask

    task automatic t_write_read;
        logic [DATA_W-1:0] d; logic v, e;
        for (int i = 0; i < DEPTH; i++) wr(ADDR_W'(i), DATA_W'(8'h11 * i + 3));
        for (int i = 0; i < DEPTH; i++) begin
            rd(ADDR_W'(i), d, v, e);
            check("R1 data", d, DATA_W'(8'h11 * i + 3));
            check("R1 rvalid", v, 1);
            check("R3 no false flag", e, 0);
        end
        u_we = 1'b1; u_re = 1'b1; u_addr = 4'd2; u_wdata = 8'hC9;
        @(negedge clk);
        u_we = 1'b0; u_re = 1'b0;
        check("R11 no rvalid on write+read", rvalid, 0);
        rd(4'd2, d, v, e);
        check("R11 write taken", d, 8'hC9);
    endtask

    task automatic t_vote;
        logic [DATA_W-1:0] d; logic v, e; int c0;
        for (int c = 0; c < 3; c++) begin
            wr(4'd7, 8'hA5);
            rd(4'd7, d, v, e);
            c0 = err_count;
            inj(2'(c), 4'd7, c + 1);
            rd(4'd7, d, v, e);
            check("R2 voted data", d, 8'hA5);
            check("R3 flag on disagreement", e, 1);
            check("R9 flip reached copy", e, 1);
            idle(1);
            check("R3 count step", err_count, c0 + 1);
        end
        wr(4'd7, 8'hA5);
        inj(2'd3, 4'd7, 0);
        rd(4'd7, d, v, e);
        check("R9 copy 3 selects none", e, 0);
        wr(4'd8, 8'h00);
        u_we = 1'b1; u_addr = 4'd8; u_wdata = 8'h5A;
        inj_en = 1'b1; inj_copy = 2'd0; inj_addr = 4'd8; inj_bit = 3'd0;
        @(negedge clk);
        u_we = 1'b0; inj_en = 1'b0;
        rd(4'd8, d, v, e);
        check("R9 write beats flip data", d, 8'h5A);
        check("R9 write beats flip flag", e, 0);
    endtask

    task automatic t_priority;
        logic [DATA_W-1:0] d; logic v, e; int s0;
        s0 = scrub_addr;
        for (int i = 0; i < 40; i++) rd(ADDR_W'(i), d, v, e);
        check("R4 scrub held under reads", scrub_addr, s0);
        for (int i = 0; i < 8; i++) wr(4'd10, 8'h4B);
        check("R4 scrub held under writes", scrub_addr, s0);
    endtask

    task automatic t_scrub_fix;
        logic [DATA_W-1:0] d; logic v, e;
        wr(4'd4, 8'h3C);
        inj(2'd1, 4'd4, 5);
        idle(4 * DEPTH + 4);
        rd(4'd4, d, v, e);
        check("R6 repaired data", d, 8'h3C);
        check("R6 repaired flag", e, 0);
        wr(4'd6, 8'h0F);
        inj(2'd0, 4'd6, 2);
        idle(4 * DEPTH + 4);
        inj(2'd1, 4'd6, 2);
        rd(4'd6, d, v, e);
        check("R6 no accumulation", d, 8'h0F);
        check("R6 second flip seen", e, 1);
    endtask

    task automatic t_pass;
        int pulses = 0; int bad = 0; int a0;
        idle(4);
        a0 = scrub_addr;
        idle(2);
        check("R5 one step per pair", scrub_addr, (a0 + 1) % DEPTH);
        for (int i = 0; i < 4 * DEPTH; i++) begin
            @(negedge clk);
            if (pass_done) begin
                pulses++;
                if (scrub_addr != 0) bad++;
            end
        end
        check("R7 pulses per window", pulses, 2);
        check("R7 pulse at zero", bad, 0);
    endtask

    task automatic t_retry;
        logic [DATA_W-1:0] d; logic v, e; int guard = 0;
        while (!pass_done && guard < 4 * DEPTH) begin
            @(negedge clk); guard++;
        end
        check("R7 wrap seen", pass_done, 1);
        idle(1);
        wr(4'd0, 8'h77);
        check("R8 address kept on conflict", scrub_addr, 0);
        idle(2);
        check("R8 retry then advance", scrub_addr, 1);
        rd(4'd0, d, v, e);
        check("R8 user write survives", d, 8'h77);
    endtask

    task automatic t_saturate;
        logic [DATA_W-1:0] d; logic v, e;
        wr(4'd9, 8'h81);
        inj(2'd2, 4'd9, 0);
        for (int i = 0; i < 300; i++) rd(4'd9, d, v, e);
        idle(1);
        check("R3 saturation", err_count, (1 << CNT_W) - 1);
        check("R2 data under saturation", d, 8'h81);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_write_read();
        t_vote();
        t_priority();
        t_scrub_fix();
        t_pass();
        t_retry();
        t_saturate();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule